// File: doc/BRIEF.md
# Ternary Multiple-Match CAM Array

This block is a register-built content addressable memory of 64 entries, each 32 bits wide. Any number of entries may hold the same value. Each entry also keeps a per-bit ignore mask and a valid flag. A search compares one key against every valid entry in a single cycle. It returns a registered vector with one bit per entry, and that bit is high when the entry matches.

Writes, masked writes and deletes are hold-style operations. The requester keeps the write enable, the address and the operation side-band steady for a fixed number of clock edges. The entry changes only on the last of those edges. If the requester lets go early, the operation is dropped and the entry is left as it was.

Entry count, word width, hold lengths and mask support are parameters. With mask support off, the per-entry mask storage is not built and every entry compares all bits.

Top module: `tcam_array`

## Requirements
- R1: After reset every entry is invalid and `match_vec` is all zeros, so a search issued before any write returns all zeros.
- R2: When `lk_start` is 1 and `wr_en` is 0 at a rising edge, `match_vec` after that edge has bit i set exactly when entry i is valid and `(lk_key ^ data_i) & ~mask_i` is zero. Several entries holding the same value set several bits.
- R3: A plain write stores `wr_data` into entry `wr_addr`, clears its mask to zero and sets it valid. A plain write is `wr_en`=1, `wr_del`=0 and `wr_mask_en`=0 with the same `wr_addr` over PLAIN_CYC (default 2) consecutive edges, and data is taken on the last edge.
- R4: A masked write stores `wr_data` and `wr_mask` and sets the entry valid. A masked write is `wr_en`=1, `wr_del`=0 and `wr_mask_en`=1 with the same address over MASK_CYC (default 3) consecutive edges. A 1 in `wr_mask` makes that bit position ignored, so value 0x0000000F with mask 0x000000F0 matches keys 0x000000FF and 0x000000EF but not 0x0000001E.
- R5: A delete marks entry `wr_addr` invalid. A delete is `wr_en`=1 and `wr_del`=1 (which takes priority over `wr_mask_en`) with the same address over DEL_CYC (default 2) consecutive edges. The entry then matches no key until a later write to that address completes.
- R6: An operation leaves every entry unchanged if `wr_en` drops, or if the operation kind or `wr_addr` changes, before its hold count is reached.
- R7: A search request while `wr_en` is 1 is ignored, and `match_vec` keeps its last value on every edge without an accepted search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write-side operation active |
| wr_addr | input | ADDR_W (6) | Entry addressed by the operation |
| wr_data | input | WIDTH (32) | Value to store |
| wr_mask_en | input | 1 | Selects a masked write |
| wr_mask | input | WIDTH (32) | Ignore mask, 1 = bit ignored |
| wr_del | input | 1 | Selects a delete |
| lk_start | input | 1 | Search request |
| lk_key | input | WIDTH (32) | Search key |
| match_vec | output | ENTRIES (64) | Registered per-entry match result |

## Verification
The hardest state to reach from the ports is a partially completed operation that is abandoned part-way. The stimulus creates it in three ways: it drops `wr_en` one edge early, it moves the address between two single-edge requests, and it raises a search strobe during a one-edge write. It then searches for both the old and the would-be new values to show that nothing moved. The array is first filled so that value v sits at every address congruent to v modulo 8, so each search must report eight-way duplicates. Full key sweeps compare every result against a bench-side model of data, mask and valid flags.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_PLAIN  = 2'd1,
      OP_MASKED = 2'd2,
      OP_DELETE = 2'd3
   } tcam_op_e;

   // Delete has priority over the mask side-band.
   function automatic tcam_op_e op_classify(input logic en, input logic del, input logic msk);
      if (!en)      return OP_NONE;
      else if (del) return OP_DELETE;
      else if (msk) return OP_MASKED;
      else          return OP_PLAIN;
   endfunction

   function automatic int unsigned op_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/tcam_wr_seq.sv
module tcam_wr_seq
   import tcam_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int PLAIN_CYC = 2,
   parameter int MASK_CYC  = 3,
   parameter int DEL_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_del,
   input  logic              wr_mask_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              commit,
   output tcam_op_e          commit_op
);

   localparam int unsigned MAX_CYC = op_max3(PLAIN_CYC, MASK_CYC, DEL_CYC);
   localparam int CNT_W = $clog2(MAX_CYC + 1);

   tcam_op_e          cur_op;
   tcam_op_e          prev_op;
   logic [ADDR_W-1:0] prev_addr;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  run;
   logic [CNT_W-1:0]  need;
   logic              same_req;

   always_comb begin
      cur_op   = op_classify(wr_en, wr_del, wr_mask_en);
      same_req = (cnt != '0) && (cur_op == prev_op) && (wr_addr == prev_addr);
      unique case (cur_op)
         OP_PLAIN:  need = CNT_W'(PLAIN_CYC);
         OP_MASKED: need = CNT_W'(MASK_CYC);
         OP_DELETE: need = CNT_W'(DEL_CYC);
         default:   need = '0;
      endcase
      if (cur_op == OP_NONE) run = '0;
      else if (same_req)     run = cnt + CNT_W'(1);
      else                   run = CNT_W'(1);
      commit    = (cur_op != OP_NONE) && (run == need);
      commit_op = cur_op;
   end

   // After a commit the count restarts, so a longer hold begins a new operation.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         prev_op   <= OP_NONE;
         prev_addr <= '0;
      end else begin
         cnt       <= commit ? '0 : run;
         prev_op   <= cur_op;
         prev_addr <= wr_addr;
      end
   end

endmodule

// File: rtl/tcam_cell.sv
module tcam_cell #(
   parameter int WIDTH   = 32,
   parameter bit MASK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_store,
   input  logic             do_kill,
   input  logic             use_mask,
   input  logic [WIDTH-1:0] in_data,
   input  logic [WIDTH-1:0] in_mask,
   input  logic [WIDTH-1:0] key,
   output logic             valid,
   output logic             hit
);

   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] care;

   always_ff @(posedge clk) begin
      if (!rst_n)        valid <= 1'b0;
      else if (do_kill)  valid <= 1'b0;
      else if (do_store) valid <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_store) data_q <= in_data;
   end

   generate
      if (MASK_EN) begin : g_ternary
         logic [WIDTH-1:0] mask_q;
         always_ff @(posedge clk) begin
            if (do_store) mask_q <= use_mask ? in_mask : '0;
         end
         assign care = ~mask_q;
      end else begin : g_binary
         assign care = '1;
      end
   endgenerate

   assign hit = valid && (((key ^ data_q) & care) == '0);

endmodule

// File: rtl/tcam_match_reg.sv
module tcam_match_reg #(
   parameter int ENTRIES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [ENTRIES-1:0] hits,
   output logic [ENTRIES-1:0] match_vec
);

   always_ff @(posedge clk) begin
      if (!rst_n)       match_vec <= '0;
      else if (capture) match_vec <= hits;
   end

endmodule

// File: rtl/tcam_array.sv
module tcam_array
   import tcam_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int WIDTH     = 32,
   parameter int PLAIN_CYC = 2,
   parameter int MASK_CYC  = 3,
   parameter int DEL_CYC   = 2,
   parameter bit MASK_EN   = 1'b1,
   localparam int ADDR_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WIDTH-1:0]   wr_data,
   input  logic               wr_mask_en,
   input  logic [WIDTH-1:0]   wr_mask,
   input  logic               wr_del,
   input  logic               lk_start,
   input  logic [WIDTH-1:0]   lk_key,
   output logic [ENTRIES-1:0] match_vec
);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("tcam_array: ENTRIES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tcam_array: WIDTH must be at least 1");
      end
      if (PLAIN_CYC < 1 || MASK_CYC < 1 || DEL_CYC < 1) begin : g_bad_hold
         $error("tcam_array: hold counts must be at least 1");
      end
   endgenerate

   logic               seq_commit;
   tcam_op_e           seq_op;
   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_hit;
   logic               is_store;
   logic               is_kill;
   logic               lk_accept;

   tcam_wr_seq #(
      .ADDR_W   (ADDR_W),
      .PLAIN_CYC(PLAIN_CYC),
      .MASK_CYC (MASK_CYC),
      .DEL_CYC  (DEL_CYC)
   ) i_wr_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_del    (wr_del),
      .wr_mask_en(wr_mask_en),
      .wr_addr   (wr_addr),
      .commit    (seq_commit),
      .commit_op (seq_op)
   );

   assign is_store  = seq_commit && (seq_op == OP_PLAIN || seq_op == OP_MASKED);
   assign is_kill   = seq_commit && (seq_op == OP_DELETE);
   assign lk_accept = lk_start && !wr_en;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         logic sel;
         assign sel = (wr_addr == ADDR_W'(e));
         tcam_cell #(
            .WIDTH  (WIDTH),
            .MASK_EN(MASK_EN)
         ) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_store(is_store && sel),
            .do_kill (is_kill && sel),
            .use_mask(seq_op == OP_MASKED),
            .in_data (wr_data),
            .in_mask (wr_mask),
            .key     (lk_key),
            .valid   (ent_valid[e]),
            .hit     (ent_hit[e])
         );
      end
   endgenerate

   tcam_match_reg #(
      .ENTRIES(ENTRIES)
   ) i_match_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (lk_accept),
      .hits     (ent_hit),
      .match_vec(match_vec)
   );

endmodule

// File: rtl/tcam_array_chk.sv
module tcam_array_chk
   import tcam_pkg::*;
#(
   parameter int ENTRIES  = 64,
   parameter int ADDR_W   = 6,
   parameter int MIN_HOLD = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic               lk_start,
   input logic [ENTRIES-1:0] match_vec,
   input logic               seq_commit,
   input tcam_op_e           seq_op,
   input logic [ENTRIES-1:0] ent_valid
);

   // R7: without an accepted search the match vector does not move
   p_hold_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_start && !wr_en) |=> $stable(match_vec));

   // R2: a search reports only entries that were valid when it was taken
   p_hits_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_start && !wr_en) |=> ((match_vec & ~$past(ent_valid)) == '0));

   // R3/R4: a completed store leaves the addressed entry valid
   p_store_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_commit && (seq_op == OP_PLAIN || seq_op == OP_MASKED))
      |=> ent_valid[$past(wr_addr)]);

   // R5: a completed delete leaves the addressed entry invalid
   p_delete_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_commit && seq_op == OP_DELETE) |=> !ent_valid[$past(wr_addr)]);

   generate
      if (MIN_HOLD >= 2) begin : g_hold_chk
         // R6: a commit needs the same request on the previous edge as well
         p_commit_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
            seq_commit |-> ($past(wr_en) && $past(wr_addr) == wr_addr));
      end
   endgenerate

endmodule

bind tcam_array tcam_array_chk #(
   .ENTRIES (ENTRIES),
   .ADDR_W  (ADDR_W),
   .MIN_HOLD((PLAIN_CYC < MASK_CYC) ? ((PLAIN_CYC < DEL_CYC) ? PLAIN_CYC : DEL_CYC)
                                    : ((MASK_CYC < DEL_CYC) ? MASK_CYC : DEL_CYC))
) i_tcam_array_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .lk_start  (lk_start),
   .match_vec (match_vec),
   .seq_commit(seq_commit),
   .seq_op    (seq_op),
   .ent_valid (ent_valid)
);

// File: tb/test_tcam_array.sv
module test_tcam_array;

   localparam int N  = 64;
   localparam int W  = 32;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic          wr_mask_en = 1'b0;
   logic [W-1:0]  wr_mask = '0;
   logic          wr_del = 1'b0;
   logic          lk_start = 1'b0;
   logic [W-1:0]  lk_key = '0;
   logic [N-1:0]  match_vec;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [W-1:0] m_data  [N];
   logic [W-1:0] m_mask  [N];
   logic         m_valid [N];

   always #5 clk = ~clk;

   tcam_array i_tcam_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_mask_en(wr_mask_en),
      .wr_mask   (wr_mask),
      .wr_del    (wr_del),
      .lk_start  (lk_start),
      .lk_key    (lk_key),
      .match_vec (match_vec)
   );

   function automatic logic [N-1:0] exp_vec(input logic [W-1:0] key);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++)
         v[i] = m_valid[i] && (((key ^ m_data[i]) & ~m_mask[i]) == '0);
      return v;
   endfunction

   task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: match_vec=%h expected %h", req, got, exp);
      end
   endtask

   task automatic release_wr();
      wr_en = 1'b0; wr_del = 1'b0; wr_mask_en = 1'b0;
   endtask

   // kind: 0 plain, 1 masked, 2 delete; cyc = edges held
   task automatic do_op(input int kind, input int addr, input logic [W-1:0] d,
                        input logic [W-1:0] m, input int cyc);
      int need;
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d; wr_mask = m;
      wr_mask_en = (kind == 1); wr_del = (kind == 2);
      repeat (cyc) @(negedge clk);
      release_wr();
      need = (kind == 1) ? 3 : 2;
      if (cyc == need) begin
         if (kind == 2) m_valid[addr] = 1'b0;
         else begin
            m_valid[addr] = 1'b1;
            m_data[addr]  = d;
            m_mask[addr]  = (kind == 1) ? m : '0;
         end
      end
   endtask

   task automatic lookup(input string req, input logic [W-1:0] key);
      lk_start = 1'b1; lk_key = key;
      @(negedge clk);
      lk_start = 1'b0;
      check(req, match_vec, exp_vec(key));
   endtask

   initial begin
      logic [N-1:0] snap;
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 1'b0; m_data[i] = '0; m_mask[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset vector", match_vec, '0);
      lookup("R1 search on empty array", 32'h0);
      lookup("R1 search on empty array", 32'hFFFF_FFFF);

      // R3: fill with duplicates, value = addr mod 8
      for (int i = 0; i < N; i++) do_op(0, i, W'(i % 8), '0, 2);
      for (int k = 0; k < 16; k++) lookup("R2 duplicate sweep", W'(k));
      lookup("R3 write stored", 32'h7);

      // R4: masked write example
      do_op(1, 2, 32'h0000_000F, 32'h0000_00F0, 3);
      lookup("R4 masked key FF", 32'h0000_00FF);
      check("R4 bit 2 set on FF", {63'b0, match_vec[2]}, 64'h1);
      lookup("R4 masked key EF", 32'h0000_00EF);
      check("R4 bit 2 set on EF", {63'b0, match_vec[2]}, 64'h1);
      lookup("R4 masked key 1E", 32'h0000_001E);
      check("R4 bit 2 clear on 1E", {63'b0, match_vec[2]}, 64'h0);
      for (int k = 0; k < 256; k++) lookup("R4 byte sweep", W'(k));

      // R3: plain write clears an earlier mask
      do_op(0, 2, 32'h0000_000F, 32'hFFFF_FFFF, 2);
      lookup("R3 mask cleared", 32'h0000_00FF);
      check("R3 bit 2 clear after plain rewrite", {63'b0, match_vec[2]}, 64'h0);

      // R5: delete, then rewrite
      do_op(2, 3, '0, '0, 2);
      lookup("R5 deleted entry", 32'h3);
      check("R5 bit 3 clear", {63'b0, match_vec[3]}, 64'h0);
      for (int k = 0; k < 16; k++) lookup("R5 sweep after delete", W'(k));
      do_op(0, 3, 32'h3, '0, 2);
      lookup("R5 rewrite restores", 32'h3);
      check("R5 bit 3 set again", {63'b0, match_vec[3]}, 64'h1);

      // R6: abandoned operations
      do_op(0, 4, 32'h0000_AAAA, '0, 1);
      lookup("R6 short plain, new value absent", 32'h0000_AAAA);
      lookup("R6 short plain, old value kept", 32'h4);
      do_op(1, 5, 32'h0000_BBBB, 32'hFFFF_0000, 2);
      lookup("R6 short masked, new value absent", 32'h0000_BBBB);
      lookup("R6 short masked, old value kept", 32'h5);
      do_op(2, 8, '0, '0, 1);
      lookup("R6 short delete, entry kept", 32'h0);
      // address moves between two single-edge requests
      wr_en = 1'b1; wr_data = 32'h0000_5555; wr_addr = AW'(6);
      @(negedge clk);
      wr_addr = AW'(7);
      @(negedge clk);
      release_wr();
      lookup("R6 address switch, no store", 32'h0000_5555);
      lookup("R6 address switch, old values", 32'h6);

      // R7: hold between searches, ignore during write
      lookup("R7 reference search", 32'h1);
      snap = match_vec;
      repeat (4) @(negedge clk);
      check("R7 idle hold", match_vec, snap);
      wr_en = 1'b1; wr_addr = AW'(9); wr_data = 32'h2;
      lk_start = 1'b1; lk_key = 32'h2;
      @(negedge clk);
      lk_start = 1'b0; release_wr();
      check("R7 search during write ignored", match_vec, snap);
      lookup("R7 back-to-back A", 32'h2);
      lookup("R7 back-to-back B", 32'h6);

      // R1: reset clears all entries
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
      check("R1 vector after second reset", match_vec, '0);
      lookup("R1 entries invalid after reset", 32'h1);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 50000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule